// File: doc/BRIEF.md
# Extended Memory Address Generator

This block builds the 16-bit data-memory address for a small 8-bit accumulator processor. It draws on three byte sources: the immediate field of the current instruction, an index register X and an index register Y. The low byte is either the immediate or X. The high byte is either X or Y, and a separate enable can force it to zero. Because X can feed the high byte, the generator offers a frame-pointer style mode in which X names a 256-byte page and the immediate picks a slot inside it. This sits beside the usual zero-page, page-indexed and auto-incrementing modes.

X is a counter that can step by one after the access that uses it, which gives the streaming post-increment mode. Both index registers load from a shared data bus on their own strobes. The address is formed combinationally from the current register values and the decoded controls, so it is valid in the same cycle as the instruction that uses it. High-byte bits above the size of the attached RAM are held at zero. By default the RAM is 32 KB, which leaves 7 significant high bits.

Top module: `mem_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, X and Y both become 0x00.
- R2: `mem_addr[7:0]` equals `d_imm` when `lo_sel_d` is 1 and equals X when it is 0, in the same cycle.
- R3: With `hi_en` at 1, the high byte `mem_addr[15:8]` shows X when `hi_sel_x` is 1 and Y when it is 0 (after the mask of R5), in the same cycle.
- R4: With `hi_en` at 0, `mem_addr[15:8]` is 0x00 whatever `hi_sel_x`, X and Y hold.
- R5: High-byte bits at index `HI_BITS` and above (default `HI_BITS` = 7, so `mem_addr[15]`) are always 0.
- R6: A 1 on `x_load` or `y_load` at a rising edge places `load_data` into X or Y, visible from that edge on. Y is unchanged while `y_load` is 0.
- R7: A 1 on `x_inc`, with `x_load` at 0, adds one to X at the rising edge. The address in the cycle of the increment still uses the old X.
- R8: When `x_load` and `x_inc` are both 1, X takes `load_data` and the increment is discarded.
- R9: X steps from 0xFF to 0x00, and Y does not change as a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| d_imm | input | 8 | Immediate byte of the instruction |
| lo_sel_d | input | 1 | Low byte source: 1 selects immediate, 0 selects X |
| hi_sel_x | input | 1 | High byte source: 1 selects X, 0 selects Y |
| hi_en | input | 1 | High byte enable: 0 forces the high byte to zero |
| x_inc | input | 1 | Step X by one after this access |
| x_load | input | 1 | Load X from load_data |
| y_load | input | 1 | Load Y from load_data |
| load_data | input | 8 | Register load data |
| mem_addr | output | 16 | Data-memory address |
| x_val | output | 8 | Current X |
| y_val | output | 8 | Current Y |

## Verification
The properties assume that the controls are settled between clock edges and that reset is held for at least one edge before other checks matter. They place no limit on how `x_load` and `x_inc` may combine. The directed stimulus changes the inputs only just after a rising edge. It drives the load and increment strobes together on purpose to exercise the priority rule. It loads Y with 0xFF so that the masked high bit is visible whenever Y or X is routed into the high byte.

// File: rtl/agen_pkg.sv
// Package agen_pkg
// Shared widths and the high-byte source type for the address generator.
// Assumes byte-wide index registers and a two-byte address.
package agen_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        HI_FROM_Y = 1'b0,
        HI_FROM_X = 1'b1
    } hi_src_e;
endpackage

// File: rtl/agen_xcount.sv
// Module agen_xcount
// X index register: a loadable byte counter that wraps modulo 2**W.
// Assumes a synchronous active-low reset; a load takes priority over a step.
module agen_xcount #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Register update: reset, then load, then post-increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (step) begin
            q <= q + ONE;
        end
    end
endmodule

// File: rtl/agen_yreg.sv
// Module agen_yreg
// Y index register: a plain loadable byte holding its value otherwise.
// Assumes a synchronous active-low reset.
module agen_yreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Register update: reset or load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/agen_hi_mux.sv
// Module agen_hi_mux
// High-byte path: picks X or Y, gates the result with the enable and
// clears every bit at or above the RAM size limit HI_BITS.
// Assumes 1 <= HI_BITS <= W.
module agen_hi_mux
    import agen_pkg::*;
#(
    parameter int W       = 8,
    parameter int HI_BITS = 7
) (
    input  hi_src_e      src,
    input  logic         en,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    output logic [W-1:0] hi
);
    logic [W-1:0] picked;

    // Source choice between the two index registers.
    always_comb begin
        picked = (src == HI_FROM_X) ? x_in : y_in;
    end

    // Per-bit gating: implemented bits follow the enable, the rest tie low.
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b < HI_BITS) begin : g_live
            assign hi[b] = en & picked[b];
        end else begin : g_dead
            assign hi[b] = 1'b0;
        end
    end
endmodule

// File: rtl/mem_addr_gen.sv
// Module mem_addr_gen
// Data-memory address generator. The low byte is the immediate or X; the
// high byte is X or Y, forced to zero when the enable is low. X may step
// after the access. The address is combinational from current state.
// Assumes decoded controls arrive stable before the clock edge.
module mem_addr_gen
    import agen_pkg::*;
#(
    parameter int HI_BITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] d_imm,
    input  logic              lo_sel_d,
    input  logic              hi_sel_x,
    input  logic              hi_en,
    input  logic              x_inc,
    input  logic              x_load,
    input  logic              y_load,
    input  logic [BYTE_W-1:0] load_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] x_val,
    output logic [BYTE_W-1:0] y_val
);
    byte_t   x_q;
    byte_t   y_q;
    byte_t   lo_byte;
    byte_t   hi_byte;
    hi_src_e hi_src;

    agen_xcount #(.W(BYTE_W)) u_x (
        .clk  (clk),
        .rst_n(rst_n),
        .load (x_load),
        .step (x_inc),
        .din  (load_data),
        .q    (x_q)
    );

    agen_yreg #(.W(BYTE_W)) u_y (
        .clk  (clk),
        .rst_n(rst_n),
        .load (y_load),
        .din  (load_data),
        .q    (y_q)
    );

    // Map the select pin onto the source type.
    always_comb begin
        hi_src = hi_sel_x ? HI_FROM_X : HI_FROM_Y;
    end

    // Low-byte selection between immediate and X.
    always_comb begin
        lo_byte = lo_sel_d ? d_imm : x_q;
    end

    agen_hi_mux #(.W(BYTE_W), .HI_BITS(HI_BITS)) u_hi (
        .src (hi_src),
        .en  (hi_en),
        .x_in(x_q),
        .y_in(y_q),
        .hi  (hi_byte)
    );

    assign mem_addr = {hi_byte, lo_byte};
    assign x_val    = x_q;
    assign y_val    = y_q;
endmodule

// File: rtl/mem_addr_gen_chk.sv
// Module mem_addr_gen_chk
// Property checker for mem_addr_gen, attached by bind below.
// Assumes inputs settle between edges; all checks are off during reset.
module mem_addr_gen_chk #(
    parameter int HI_BITS = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  d_imm,
    input logic        lo_sel_d,
    input logic        hi_sel_x,
    input logic        hi_en,
    input logic        x_inc,
    input logic        x_load,
    input logic        y_load,
    input logic [7:0]  load_data,
    input logic [15:0] mem_addr,
    input logic [7:0]  x_val,
    input logic [7:0]  y_val
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (x_val == 8'h00 && y_val == 8'h00));

    a_r2_low_imm: assert property (@(posedge clk) disable iff (!rst_n)
        lo_sel_d |-> mem_addr[7:0] == d_imm);

    a_r2_low_x: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_sel_d |-> mem_addr[7:0] == x_val);

    a_r4_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_en |-> mem_addr[15:8] == 8'h00);

    a_r5_top_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        (HI_BITS < 8) |-> !mem_addr[15]);

    a_r6_y_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !y_load |=> $stable(y_val));

    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (x_inc && !x_load) |=> x_val == $past(x_val) + 8'h01);

    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        x_load |=> x_val == $past(load_data));
endmodule

bind mem_addr_gen mem_addr_gen_chk #(.HI_BITS(HI_BITS)) u_chk (.*);

// File: tb/sim_mem_addr_gen.sv
// Directed bench for mem_addr_gen: one task per scenario.
module sim_mem_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  d_imm;
    logic        lo_sel_d, hi_sel_x, hi_en, x_inc, x_load, y_load;
    logic [7:0]  load_data;
    logic [15:0] mem_addr;
    logic [7:0]  x_val, y_val;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mem_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .d_imm(d_imm), .lo_sel_d(lo_sel_d),
        .hi_sel_x(hi_sel_x), .hi_en(hi_en), .x_inc(x_inc), .x_load(x_load),
        .y_load(y_load), .load_data(load_data), .mem_addr(mem_addr),
        .x_val(x_val), .y_val(y_val)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance past one rising edge, then idle the strobes.
    task automatic tick();
        @(posedge clk);
        #1;
        x_inc = 0; x_load = 0; y_load = 0;
    endtask

    task automatic load_regs(input logic [7:0] xv, input logic [7:0] yv);
        load_data = xv; x_load = 1; tick();
        load_data = yv; y_load = 1; tick();
    endtask

    task automatic t_reset();
        rst_n = 0; tick(); tick();
        chk("R1 x after reset", {8'h00, x_val}, 16'h0000);
        chk("R1 y after reset", {8'h00, y_val}, 16'h0000);
        rst_n = 1; tick();
    endtask

    task automatic t_low();
        load_regs(8'h3C, 8'h21);
        hi_en = 0; d_imm = 8'hA5; lo_sel_d = 1; #1;
        chk("R2 low from imm", mem_addr, 16'h00A5);
        lo_sel_d = 0; #1;
        chk("R2 low from X", mem_addr, 16'h003C);
    endtask

    task automatic t_high();
        hi_en = 1; hi_sel_x = 0; lo_sel_d = 1; d_imm = 8'h10; #1;
        chk("R3 [Y,D]", mem_addr, 16'h2110);
        hi_sel_x = 1; #1;
        chk("R3 [X,D] frame", mem_addr, 16'h3C10);
        lo_sel_d = 0; hi_sel_x = 0; #1;
        chk("R3 [Y,X]", mem_addr, 16'h213C);
    endtask

    task automatic t_hi_off();
        load_regs(8'h55, 8'h66);
        hi_en = 0; lo_sel_d = 1; d_imm = 8'h77;
        hi_sel_x = 1; #1;
        chk("R4 disabled sel X", mem_addr, 16'h0077);
        hi_sel_x = 0; #1;
        chk("R4 disabled sel Y", mem_addr, 16'h0077);
    endtask

    task automatic t_mask();
        load_regs(8'hC3, 8'hFF);
        hi_en = 1; hi_sel_x = 0; lo_sel_d = 1; d_imm = 8'h01; #1;
        chk("R5 Y=FF masked", mem_addr, 16'h7F01);
        hi_sel_x = 1; #1;
        chk("R5 X=C3 masked", mem_addr, 16'h4301);
    endtask

    task automatic t_load();
        load_data = 8'h9A; x_load = 1; #1;
        chk("R6 X not yet loaded", {8'h00, x_val}, 16'h00C3);
        tick();
        chk("R6 X loaded", {8'h00, x_val}, 16'h009A);
        chk("R6 Y held", {8'h00, y_val}, 16'h00FF);
        load_data = 8'h12; y_load = 1; tick();
        chk("R6 Y loaded", {8'h00, y_val}, 16'h0012);
    endtask

    task automatic t_inc();
        load_regs(8'h40, 8'h05);
        hi_en = 1; hi_sel_x = 0; lo_sel_d = 0; x_inc = 1; #1;
        chk("R7 old X used in access", mem_addr, 16'h0540);
        tick();
        chk("R7 X stepped", {8'h00, x_val}, 16'h0041);
        x_inc = 1; tick();
        x_inc = 1; tick();
        chk("R7 X after three steps", {8'h00, x_val}, 16'h0043);
    endtask

    task automatic t_priority();
        load_data = 8'hE0; x_load = 1; x_inc = 1; tick();
        chk("R8 load beats step", {8'h00, x_val}, 16'h00E0);
    endtask

    task automatic t_wrap();
        load_regs(8'hFF, 8'h33);
        x_inc = 1; tick();
        chk("R9 X wraps to 00", {8'h00, x_val}, 16'h0000);
        chk("R9 Y untouched", {8'h00, y_val}, 16'h0033);
    endtask

    initial begin
        rst_n = 0; d_imm = 0; lo_sel_d = 0; hi_sel_x = 0; hi_en = 0;
        x_inc = 0; x_load = 0; y_load = 0; load_data = 0;
        t_reset();
        t_low();
        t_high();
        t_hi_off();
        t_mask();
        t_load();
        t_inc();
        t_priority();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule